// File: doc/BRIEF.md
# Posit Word Encoder with Round-to-Nearest-Even

This block turns an unpacked real value into an n-bit posit word in a single combinational path. The value arrives as a sign bit, a signed power-of-two scale, a fraction (the bits after the hidden leading one, MSB aligned) and two flags for the zero and Not-a-Real cases. It is the back end of any posit datapath: an adder, multiplier or accumulator works on the unpacked form, and this encoder packs its result.

The scale is cut into a regime value `k` (the scale divided by 2^ES, rounded toward minus infinity) and an exponent `e` (the remainder). The regime is emitted as a run-length code, followed by the exponent bits and then as many fraction bits as still fit. Everything past the last kept bit goes into a guard bit and a sticky bit. The kept bits are rounded to nearest with ties to even. The position of that rounding point depends on the regime length, so it shifts with the magnitude. The rounding saturates, so a nonzero value never turns into zero or Not-a-Real. A negative value is produced as the two's complement of the positive word.

Word width `N_BITS` and exponent width `ES_BITS` are parameters, with defaults of 16 and 1. `FRAC_W` sets the width of the input fraction and `SCALE_W` sets the width of the input scale.

Top module: `posit_encoder`

## Requirements
- R1: Below the sign bit, the output is the regime, then ES_BITS exponent bits, then fraction bits taken MSB first. Every word apart from zero and NaR decodes back to the same sign, scale and fraction when fed to the encoder.
- R2: For k >= 0 the regime is k+1 ones followed by a zero. For k < 0 it is -k zeros followed by a one.
- R3: k = floor(scale / 2^ES_BITS) and e = scale mod 2^ES_BITS, which also holds for negative scales. For example, with ES_BITS=1 a scale of -1 gives k=-1 and e=1, which encodes as 0x3000 when the fraction is zero.
- R4: With nar_i high, the output is 1 followed by N_BITS-1 zeros (0x8000 at the defaults), whatever the other inputs are. With zero_i high and nar_i low, the output is all zeros, whatever the sign is.
- R5: Dropped bits are rounded to nearest. An exact tie rounds to the even kept word. Guard is the first dropped bit and sticky is the OR of all later dropped bits.
- R6: A nonzero input never yields zero or NaR. A scale above (N_BITS-2)*2^ES_BITS gives maxpos (0x7FFF), and a scale below -(N_BITS-2)*2^ES_BITS gives minpos (0x0001). Rounding up never carries past maxpos.
- R7: When sign_i is 1, the output is the two's complement of the positive encoding of the same magnitude.
- R8: When the regime run fills all N_BITS-1 bits, no terminating bit is emitted, and the guard and sticky bits then come from the terminator and the bits after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sign_i | input | 1 | Sign of the value (1 = negative) |
| scale_i | input | SCALE_W | Signed power-of-two scale |
| frac_i | input | FRAC_W | Fraction bits after the hidden one, MSB first |
| zero_i | input | 1 | Value is zero |
| nar_i | input | 1 | Value is Not-a-Real; takes priority over zero_i |
| posit_o | output | N_BITS | Encoded posit word |

## Verification
The bench decodes every one of the 65534 nonzero, non-NaR words back into sign, scale and fraction, and requires the encoder to return the same word. This round trip catches a regime of the wrong length, a scale split that rounds toward zero for negative scales, and an exponent or fraction placed at the wrong offset. Directed cases then sit exactly on the rounding boundary at two different regime lengths. A design that rounds ties away from zero, or that ignores sticky, gives a word one code off. Further cases force the scale far past both ends of the range: a design that fails to saturate wraps into NaR or collapses to zero. A case at the longest regime length shows whether a terminating bit was wrongly kept. The negative-value checks show whether the design negates the wrong word, for example by taking a one's complement or negating before rounding.

// File: rtl/posit_enc_pkg.sv
package posit_enc_pkg;

  typedef enum logic [1:0] {
    VK_NUM  = 2'd0,
    VK_ZERO = 2'd1,
    VK_NAR  = 2'd2
  } val_kind_e;

  // NaR wins over zero
  function automatic val_kind_e classify(input logic zero, input logic nar);
    if (nar)       return VK_NAR;
    else if (zero) return VK_ZERO;
    else           return VK_NUM;
  endfunction

  function automatic int max_scale(input int n, input int es);
    return (n - 2) << es;
  endfunction

endpackage

// File: rtl/posit_scale_split.sv
module posit_scale_split
  import posit_enc_pkg::*;
#(
  parameter int N_BITS  = 16,
  parameter int ES_BITS = 1,
  parameter int SCALE_W = 8,
  parameter int KW      = $clog2(N_BITS) + 1
) (
  input  logic signed [SCALE_W-1:0] scale_i,
  output logic signed [KW-1:0]      k_o,
  output logic        [ES_BITS-1:0] exp_o,
  output logic                      clamp_o
);
  localparam int MAXS = max_scale(N_BITS, ES_BITS);
  localparam int MINS = -MAXS;

  int sc_raw;
  int sc;
  int kk;

  always_comb begin
    sc_raw  = int'(scale_i);
    clamp_o = (sc_raw > MAXS) || (sc_raw < MINS);
    if (sc_raw > MAXS)      sc = MAXS;
    else if (sc_raw < MINS) sc = MINS;
    else                    sc = sc_raw;
    kk    = sc >>> ES_BITS;  // floor division
    k_o   = KW'(kk);
    exp_o = sc[ES_BITS-1:0];
  end

  always_comb begin
    p_k_range_r3: assert (int'(k_o) <= N_BITS - 2 && int'(k_o) >= -(N_BITS - 2))
      else $error("k out of range");
    if (!clamp_o)
      p_split_sum_r3: assert ((int'(k_o) << ES_BITS) + int'(exp_o) == sc_raw)
        else $error("scale split mismatch");
  end

endmodule

// File: rtl/posit_regime_packer.sv
module posit_regime_packer #(
  parameter int N_BITS  = 16,
  parameter int ES_BITS = 1,
  parameter int FRAC_W  = 16,
  parameter int KW      = $clog2(N_BITS) + 1
) (
  input  logic signed [KW-1:0]      k_i,
  input  logic        [ES_BITS-1:0] exp_i,
  input  logic        [FRAC_W-1:0]  frac_i,
  input  logic                      kill_tail_i,
  output logic        [N_BITS-2:0]  body_o,
  output logic                      guard_o,
  output logic                      sticky_o
);
  localparam int TW = ES_BITS + FRAC_W;
  localparam int XW = N_BITS + TW;

  logic [TW-1:0] tail;
  logic [XW-1:0] ext;
  logic [XW-1:0] sh;
  int            amt;

  always_comb begin
    tail = kill_tail_i ? '0 : {exp_i, frac_i};
    if (k_i >= 0) begin
      ext = {{(N_BITS-1){1'b1}}, 1'b0, tail};
      amt = N_BITS - 2 - int'(k_i);
    end else begin
      ext = {{(N_BITS-1){1'b0}}, 1'b1, tail};
      amt = N_BITS - 1 + int'(k_i);
    end
    sh       = ext << amt;
    body_o   = sh[XW-1 -: N_BITS-1];
    guard_o  = sh[XW-N_BITS];
    sticky_o = |sh[XW-N_BITS-1:0];
  end

  always_comb begin
    p_regime_lead_r2: assert (body_o[N_BITS-2] == (k_i >= 0))
      else $error("regime lead bit wrong");
    if (int'(k_i) == N_BITS - 2)
      p_full_run_r8: assert (&body_o && !guard_o)
        else $error("full regime run malformed");
  end

endmodule

// File: rtl/posit_rne_round.sv
module posit_rne_round #(
  parameter int N_BITS = 16
) (
  input  logic [N_BITS-2:0] body_i,
  input  logic              guard_i,
  input  logic              sticky_i,
  output logic [N_BITS-2:0] mag_o
);
  logic at_max;
  logic inc;

  always_comb begin
    at_max = &body_i;
    inc    = guard_i & (body_i[0] | sticky_i) & ~at_max;
    mag_o  = body_i + {{(N_BITS-2){1'b0}}, inc};
  end

  always_comb begin
    p_round_step_r5: assert (mag_o == body_i || mag_o == body_i + 1'b1)
      else $error("rounding moved more than one code");
    if (body_i != '0)
      p_no_underflow_r6: assert (mag_o != '0) else $error("rounded to zero");
  end

endmodule

// File: rtl/posit_encoder.sv
module posit_encoder
  import posit_enc_pkg::*;
#(
  parameter int N_BITS  = 16,
  parameter int ES_BITS = 1,
  parameter int FRAC_W  = 16,
  parameter int SCALE_W = 8
) (
  input  logic                      sign_i,
  input  logic signed [SCALE_W-1:0] scale_i,
  input  logic        [FRAC_W-1:0]  frac_i,
  input  logic                      zero_i,
  input  logic                      nar_i,
  output logic        [N_BITS-1:0]  posit_o
);
  localparam int KW = $clog2(N_BITS) + 1;
  localparam logic [N_BITS-1:0] NAR_WORD = {1'b1, {(N_BITS-1){1'b0}}};

  logic signed [KW-1:0]      k_w;
  logic        [ES_BITS-1:0] exp_w;
  logic                      clamp_w;
  logic        [N_BITS-2:0]  body_w;
  logic                      guard_w;
  logic                      sticky_w;
  logic        [N_BITS-2:0]  mag_w;
  logic        [N_BITS-1:0]  pos_w;
  val_kind_e                 kind;

  posit_scale_split #(
    .N_BITS(N_BITS), .ES_BITS(ES_BITS), .SCALE_W(SCALE_W), .KW(KW)
  ) u_split (
    .scale_i (scale_i),
    .k_o     (k_w),
    .exp_o   (exp_w),
    .clamp_o (clamp_w)
  );

  posit_regime_packer #(
    .N_BITS(N_BITS), .ES_BITS(ES_BITS), .FRAC_W(FRAC_W), .KW(KW)
  ) u_pack (
    .k_i         (k_w),
    .exp_i       (exp_w),
    .frac_i      (frac_i),
    .kill_tail_i (clamp_w),
    .body_o      (body_w),
    .guard_o     (guard_w),
    .sticky_o    (sticky_w)
  );

  posit_rne_round #(.N_BITS(N_BITS)) u_round (
    .body_i   (body_w),
    .guard_i  (guard_w),
    .sticky_i (sticky_w),
    .mag_o    (mag_w)
  );

  always_comb begin
    kind  = classify(zero_i, nar_i);
    pos_w = {1'b0, mag_w};
    case (kind)
      VK_NAR:  posit_o = NAR_WORD;
      VK_ZERO: posit_o = '0;
      default: posit_o = sign_i ? (~pos_w + 1'b1) : pos_w;
    endcase
  end

  always_comb begin
    if (kind == VK_NUM) begin
      p_nonzero_out_r6: assert (posit_o != '0 && posit_o != NAR_WORD)
        else $error("nonzero value encoded as zero or NaR");
      p_sign_bit_r7: assert (posit_o[N_BITS-1] == sign_i)
        else $error("sign bit mismatch");
    end
  end

endmodule

// File: tb/posit_encoder_bench.sv
module posit_encoder_bench;
  localparam int N  = 16;
  localparam int ES = 1;
  localparam int FW = 16;
  localparam int SW = 8;

  logic                 clk = 1'b0;
  logic                 sign_i = 1'b0;
  logic signed [SW-1:0] scale_i = '0;
  logic [FW-1:0]        frac_i = '0;
  logic                 zero_i = 1'b0;
  logic                 nar_i = 1'b0;
  logic [N-1:0]         posit_o;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  posit_encoder #(.N_BITS(N), .ES_BITS(ES), .FRAC_W(FW), .SCALE_W(SW)) u_posit_encoder (
    .sign_i (sign_i),
    .scale_i(scale_i),
    .frac_i (frac_i),
    .zero_i (zero_i),
    .nar_i  (nar_i),
    .posit_o(posit_o)
  );

  task automatic apply(input logic s, input int sc, input logic [FW-1:0] f,
                       input logic z, input logic n);
    @(posedge clk);
    sign_i  = s;
    scale_i = SW'(sc);
    frac_i  = f;
    zero_i  = z;
    nar_i   = n;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [N-1:0] exp_w);
    n_vec++;
    if (posit_o !== exp_w) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (s=%0b sc=%0d f=%h z=%0b n=%0b)",
               req, posit_o, exp_w, sign_i, scale_i, frac_i, zero_i, nar_i);
    end
  endtask

  function automatic void ref_decode(input logic [N-1:0] p, output logic s,
                                     output int sc, output logic [FW-1:0] f);
    logic [N-1:0] m;
    logic         first;
    int           run;
    int           i;
    int           k;
    int           e;
    int           fp;
    s     = p[N-1];
    m     = s ? (~p + 1'b1) : p;
    first = m[N-2];
    run   = 0;
    i     = N - 2;
    while (i >= 0 && m[i] == first) begin run++; i--; end
    k = first ? run - 1 : -run;
    i--;
    e = 0;
    for (int j = 0; j < ES; j++) begin
      e = e << 1;
      if (i >= 0) begin e = e | int'(m[i]); i--; end
    end
    f  = '0;
    fp = FW - 1;
    while (i >= 0) begin f[fp] = m[i]; fp--; i--; end
    sc = k * (1 << ES) + e;
  endfunction

  // R1 R2 R3 R7 R8: round trip over every ordinary word
  task automatic t_round_trip();
    logic          s;
    int            sc;
    logic [FW-1:0] f;
    for (int p = 1; p < (1 << N); p++) begin
      if (p != (1 << (N - 1))) begin
        ref_decode(N'(p), s, sc, f);
        apply(s, sc, f, 1'b0, 1'b0);
        check("R1 round trip", N'(p));
      end
    end
  endtask

  task automatic t_special();
    apply(1'b0, 5, 16'hABCD, 1'b1, 1'b0); check("R4 zero", 16'h0000);
    apply(1'b1, 5, 16'hABCD, 1'b1, 1'b0); check("R4 negative zero", 16'h0000);
    apply(1'b0, 0, 16'h0000, 1'b0, 1'b1); check("R4 NaR", 16'h8000);
    apply(1'b1, -3, 16'h1234, 1'b1, 1'b1); check("R4 NaR over zero", 16'h8000);
  endtask

  task automatic t_split();
    apply(1'b0, -1, 16'h0000, 1'b0, 1'b0); check("R3 scale -1", 16'h3000);
    apply(1'b0, 3, 16'h0000, 1'b0, 1'b0);  check("R3 scale 3", 16'h6800);
    apply(1'b0, 0, 16'h0000, 1'b0, 1'b0);  check("R2 scale 0", 16'h4000);
  endtask

  task automatic t_rounding();
    apply(1'b0, 0, 16'h0008, 1'b0, 1'b0);  check("R5 tie even down", 16'h4000);
    apply(1'b0, 0, 16'h0018, 1'b0, 1'b0);  check("R5 tie odd up", 16'h4002);
    apply(1'b0, 0, 16'h0009, 1'b0, 1'b0);  check("R5 above half", 16'h4001);
    apply(1'b0, 0, 16'h0007, 1'b0, 1'b0);  check("R5 below half", 16'h4000);
    apply(1'b0, -27, 16'h0000, 1'b0, 1'b0); check("R5 tie at long regime", 16'h0002);
    apply(1'b1, 0, 16'h0009, 1'b0, 1'b0);  check("R7 negative rounded", 16'hBFFF);
  endtask

  task automatic t_saturate();
    apply(1'b0, 100, 16'hFFFF, 1'b0, 1'b0);  check("R6 clamp maxpos", 16'h7FFF);
    apply(1'b0, -100, 16'hFFFF, 1'b0, 1'b0); check("R6 clamp minpos", 16'h0001);
    apply(1'b1, -100, 16'h0000, 1'b0, 1'b0); check("R6 R7 clamp -minpos", 16'hFFFF);
    apply(1'b1, 100, 16'h0000, 1'b0, 1'b0);  check("R6 R7 clamp -maxpos", 16'h8001);
    apply(1'b0, 28, 16'hFFFF, 1'b0, 1'b0);   check("R8 full run no NaR", 16'h7FFF);
    apply(1'b0, 27, 16'h0000, 1'b0, 1'b0);   check("R8 tie below maxpos", 16'h7FFE);
    apply(1'b0, 27, 16'h0001, 1'b0, 1'b0);   check("R6 round into maxpos", 16'h7FFF);
    apply(1'b0, -28, 16'hFFFF, 1'b0, 1'b0);  check("R6 minpos keeps", 16'h0001);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R4 initial zero-flag-free state", 16'h4000);
    t_special();
    t_split();
    t_rounding();
    t_saturate();
    t_round_trip();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule